// File: doc/BRIEF.md
# Multi-port PHY reset sequencer

This controller sequences reset and clock enables for a four-port 10/100 Ethernet transceiver core. Two reset sources, an active-high hardware reset and a power-on reset, are ORed together. The combined reset takes effect asynchronously. Its release is synchronised to the local clock. While the combined reset is active, every port is held busy.

Each port has a 10 Mb/s section and a 100 Mb/s section. Each section stays in reset until its enable request is high. From then on it needs a fixed hold time (1.3 ms in the target system) before it leaves reset. The hold time is a cycle count. By default it is derived from the system clock frequency by a package function; benches override it with a short value. A port's overall busy flag is high while either of its sections is busy or the global reset is active.

The same block drives the power-up enables of the two PLLs from the enabled modes and from the bypass overrides. It also flags the illegal case where both clock-source selects are high.

Top module: `phy_rst_seq`

## Requirements
- R1: A high level on `hw_rst`, even one much shorter than a clock period, forces every bit of `busy`, `busy10` and `busy100` high at once, without waiting for a clock edge.
- R2: `por_rst` is a second reset source with the same effect as `hw_rst`; it can stay tied low when unused.
- R3: After the last reset source goes low, the global reset ends on the second rising clock edge (`SYNC_STAGES` = 2). Section counting starts with the edge after that.
- R4: `busy10[p]` stays high while `en10[p]` is low. Once `en10[p]` is high, `busy10[p]` goes low after `HOLD_CYCLES` consecutive rising edges, outside global reset, at which `en10[p]` is sampled high.
- R5: `busy100[p]` follows the same rule as R4, driven by `en100[p]`.
- R6: If a section's enable is sampled low, the section returns to reset on that edge and its count clears. This holds while it is counting, on the terminal edge itself, or after it has been released. A later enable must wait the full `HOLD_CYCLES` again.
- R7: `busy[p]` is low only when the global reset is inactive and both `busy10[p]` and `busy100[p]` are low.
- R8: `pll160_en` is registered. It is high one cycle after any bit of `en10` is high or `byp160` is high, and low otherwise.
- R9: `pll125_en` is registered. It is high one cycle after any bit of `en100`, `byp125` or `in125_sel` is high, and low otherwise.
- R10: `clk_sel_err` is registered. It is high one cycle after `sel_ref` and `sel_xtl` are both high, and low otherwise.
- R11: The sections of different ports are independent. Enabling or dropping one section changes no other section's busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| hw_rst | input | 1 | Hardware reset, active high, asynchronous |
| por_rst | input | 1 | Power-on reset, active high; tie low if unused |
| en10 | input | NPORTS | Per-port 10 Mb/s section enable request |
| en100 | input | NPORTS | Per-port 100 Mb/s section enable request |
| byp160 | input | 1 | Keep the 160 MHz PLL powered regardless of mode |
| byp125 | input | 1 | Keep the 125 MHz PLL powered regardless of mode |
| in125_sel | input | 1 | Reference clock is 125 MHz (forces the 125 MHz PLL on) |
| sel_ref | input | 1 | Select external reference clock |
| sel_xtl | input | 1 | Select crystal clock |
| busy | output | NPORTS | Per-port overall reset-in-progress flag |
| busy10 | output | NPORTS | Per-port 10 Mb/s section in reset |
| busy100 | output | NPORTS | Per-port 100 Mb/s section in reset |
| pll160_en | output | 1 | 160 MHz PLL power-up enable |
| pll125_en | output | 1 | 125 MHz PLL power-up enable |
| clk_sel_err | output | 1 | Both clock-source selects high |

## Verification
Two events can fall in the same cycle: a section's timer reaching its terminal count, and its enable being withdrawn. The bench arms a 100 Mb/s section and lets it count to one short of the terminal value. It then drops the enable so that it is sampled low on exactly the edge that would release the section. The section must stay busy, and on re-enable it must wait the full hold time again. A second collision puts a sub-cycle hardware reset pulse on ports that have already been released. All flags must rise immediately, and release must again take two sync edges plus the full hold.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

  // Cycles needed to cover hold_us microseconds at clk_hz, rounded up.
  function automatic int unsigned hold_cycles(longint unsigned clk_hz, longint unsigned hold_us);
    longint unsigned prod;
    prod = clk_hz * hold_us;
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // Counter width able to hold values 0..n.
  function automatic int unsigned count_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= 1'b1;
        else      chain <= 1'b0;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= '1;
        else      chain <= {chain[STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/phy_sect_timer.sv
module phy_sect_timer #(
  parameter int unsigned HOLD = 20,
  parameter int unsigned CW   = phy_rst_pkg::count_width(HOLD)
) (
  input  logic clk,
  input  logic glob_rst,
  input  logic en,
  output logic busy_o,
  output logic term_o
);
  logic [CW-1:0] cnt;
  logic          done;

  // Terminal edge: enabled, not yet released, count at its last value.
  assign term_o = en && !done && (cnt == CW'(HOLD - 1));

  always_ff @(posedge clk or posedge glob_rst) begin
    if (glob_rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (term_o) done <= 1'b1;
      else        cnt  <= cnt + 1'b1;
    end
  end

  assign busy_o = ~done;
endmodule

// File: rtl/phy_clk_ctl.sv
module phy_clk_ctl #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic [NPORTS-1:0] en10,
  input  logic [NPORTS-1:0] en100,
  input  logic              byp160,
  input  logic              byp125,
  input  logic              in125_sel,
  input  logic              sel_ref,
  input  logic              sel_xtl,
  output logic              pll160_en,
  output logic              pll125_en,
  output logic              clk_sel_err
);
  logic want160, want125, conflict;

  assign want160  = (|en10) | byp160;
  assign want125  = (|en100) | byp125 | in125_sel;
  assign conflict = sel_ref & sel_xtl;

  // PLL control must not be cleared by the port reset: bypass overrides
  // keep the PLLs running through it.
  always_ff @(posedge clk) begin
    pll160_en   <= want160;
    pll125_en   <= want125;
    clk_sel_err <= conflict;
  end
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int          NPORTS      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter longint      CLK_HZ      = 25_000_000,
  parameter longint      HOLD_US     = 1300,
  parameter int unsigned HOLD_CYCLES = phy_rst_pkg::hold_cycles(CLK_HZ, HOLD_US)
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              por_rst,
  input  logic [NPORTS-1:0] en10,
  input  logic [NPORTS-1:0] en100,
  input  logic              byp160,
  input  logic              byp125,
  input  logic              in125_sel,
  input  logic              sel_ref,
  input  logic              sel_xtl,
  output logic [NPORTS-1:0] busy,
  output logic [NPORTS-1:0] busy10,
  output logic [NPORTS-1:0] busy100,
  output logic              pll160_en,
  output logic              pll125_en,
  output logic              clk_sel_err
);
  localparam int unsigned CW = phy_rst_pkg::count_width(HOLD_CYCLES);

  logic              any_rst;
  logic              glob_rst;
  logic [NPORTS-1:0] term10;
  logic [NPORTS-1:0] term100;

  assign any_rst = hw_rst | por_rst;

  phy_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .arst  (any_rst),
    .rst_o (glob_rst)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    phy_sect_timer #(.HOLD(HOLD_CYCLES), .CW(CW)) u_t10 (
      .clk      (clk),
      .glob_rst (glob_rst),
      .en       (en10[p]),
      .busy_o   (busy10[p]),
      .term_o   (term10[p])
    );
    phy_sect_timer #(.HOLD(HOLD_CYCLES), .CW(CW)) u_t100 (
      .clk      (clk),
      .glob_rst (glob_rst),
      .en       (en100[p]),
      .busy_o   (busy100[p]),
      .term_o   (term100[p])
    );
    assign busy[p] = glob_rst | busy10[p] | busy100[p];
  end

  phy_clk_ctl #(.NPORTS(NPORTS)) u_clk (
    .clk         (clk),
    .en10        (en10),
    .en100       (en100),
    .byp160      (byp160),
    .byp125      (byp125),
    .in125_sel   (in125_sel),
    .sel_ref     (sel_ref),
    .sel_xtl     (sel_xtl),
    .pll160_en   (pll160_en),
    .pll125_en   (pll125_en),
    .clk_sel_err (clk_sel_err)
  );
endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              hw_rst,
  input logic              por_rst,
  input logic              glob_rst,
  input logic [NPORTS-1:0] en10,
  input logic [NPORTS-1:0] en100,
  input logic              byp160,
  input logic              byp125,
  input logic              in125_sel,
  input logic              sel_ref,
  input logic              sel_xtl,
  input logic [NPORTS-1:0] term10,
  input logic [NPORTS-1:0] term100,
  input logic [NPORTS-1:0] busy,
  input logic [NPORTS-1:0] busy10,
  input logic [NPORTS-1:0] busy100,
  input logic              pll160_en,
  input logic              pll125_en,
  input logic              clk_sel_err
);
  a_r1_hw_forces_busy: assert property (@(posedge clk) disable iff (por_rst)
    hw_rst |-> (&busy && &busy10 && &busy100));

  a_r2_por_forces_busy: assert property (@(posedge clk) disable iff (hw_rst)
    por_rst |-> (&busy && &busy10 && &busy100));

  a_r8_pll160_follow: assert property (@(posedge clk) disable iff (glob_rst)
    1'b1 |=> (pll160_en == ($past(|en10) || $past(byp160))));

  a_r9_pll125_follow: assert property (@(posedge clk) disable iff (glob_rst)
    1'b1 |=> (pll125_en == ($past(|en100) || $past(byp125) || $past(in125_sel))));

  a_r10_sel_conflict: assert property (@(posedge clk) disable iff (glob_rst)
    1'b1 |=> (clk_sel_err == ($past(sel_ref) && $past(sel_xtl))));

  for (genvar p = 0; p < NPORTS; p++) begin : g_p
    a_r4_term_releases10: assert property (@(posedge clk) disable iff (glob_rst)
      term10[p] |=> !busy10[p]);
    a_r4_release_only_at_term10: assert property (@(posedge clk) disable iff (glob_rst)
      $fell(busy10[p]) |-> $past(term10[p]));
    a_r5_term_releases100: assert property (@(posedge clk) disable iff (glob_rst)
      term100[p] |=> !busy100[p]);
    a_r5_release_only_at_term100: assert property (@(posedge clk) disable iff (glob_rst)
      $fell(busy100[p]) |-> $past(term100[p]));
    a_r6_disable_returns10: assert property (@(posedge clk) disable iff (glob_rst)
      !en10[p] |=> busy10[p]);
    a_r6_disable_returns100: assert property (@(posedge clk) disable iff (glob_rst)
      !en100[p] |=> busy100[p]);
    a_r7_idle_needs_both: assert property (@(posedge clk) disable iff (glob_rst)
      !busy[p] |-> (!busy10[p] && !busy100[p]));
  end
endmodule

bind phy_rst_seq phy_rst_seq_chk #(.NPORTS(NPORTS)) u_chk (
  .clk         (clk),
  .hw_rst      (hw_rst),
  .por_rst     (por_rst),
  .glob_rst    (glob_rst),
  .en10        (en10),
  .en100       (en100),
  .byp160      (byp160),
  .byp125      (byp125),
  .in125_sel   (in125_sel),
  .sel_ref     (sel_ref),
  .sel_xtl     (sel_xtl),
  .term10      (term10),
  .term100     (term100),
  .busy        (busy),
  .busy10      (busy10),
  .busy100     (busy100),
  .pll160_en   (pll160_en),
  .pll125_en   (pll125_en),
  .clk_sel_err (clk_sel_err)
);

// File: tb/phy_rst_seq_bench.sv
module phy_rst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 4;
  localparam int HOLD       = 20;

  logic          clk = 1'b0;
  logic          hw_rst = 1'b1, por_rst = 1'b0;
  logic [NP-1:0] en10 = '0, en100 = '0;
  logic          byp160 = 0, byp125 = 0, in125_sel = 0, sel_ref = 0, sel_xtl = 0;
  logic [NP-1:0] busy, busy10, busy100;
  logic          pll160_en, pll125_en, clk_sel_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_rst_seq #(.NPORTS(NP), .HOLD_CYCLES(HOLD)) u_phy_rst_seq (
    .clk(clk), .hw_rst(hw_rst), .por_rst(por_rst), .en10(en10), .en100(en100),
    .byp160(byp160), .byp125(byp125), .in125_sel(in125_sel),
    .sel_ref(sel_ref), .sel_xtl(sel_xtl),
    .busy(busy), .busy10(busy10), .busy100(busy100),
    .pll160_en(pll160_en), .pll125_en(pll125_en), .clk_sel_err(clk_sel_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    cyc(2);
    chk("R1 busy in reset", busy, 4'hF);
    chk("R1 busy10 in reset", busy10, 4'hF);
    hw_rst = 1'b0;
    cyc(HOLD + 4);
    chk("R4 no enable keeps busy10", busy10, 4'hF);
    chk("R5 no enable keeps busy100", busy100, 4'hF);
  endtask

  task automatic t_bring_up;
    en10 = 4'hF; en100 = 4'hF; hw_rst = 1'b1;
    cyc(1);
    hw_rst = 1'b0;
    cyc(HOLD + 1);
    chk("R3 still busy one edge early", busy10, 4'hF);
    chk("R7 busy one edge early", busy, 4'hF);
    cyc(1);
    chk("R4 busy10 released", busy10, 4'h0);
    chk("R5 busy100 released", busy100, 4'h0);
    chk("R7 port idle", busy, 4'h0);
  endtask

  task automatic t_section_restart;
    en10[1] = 1'b0;
    cyc(1);
    chk("R6 drop returns to reset", busy10, 4'b0010);
    chk("R11 other ports untouched", {busy100, busy}, {4'h0, 4'b0010});
    en10[1] = 1'b1;
    cyc(HOLD - 1);
    chk("R6 full recount", busy10, 4'b0010);
    cyc(1);
    chk("R6 released after recount", busy10, 4'h0);
  endtask

  task automatic t_drop_at_terminal;
    en100[2] = 1'b0;
    cyc(1);
    en100[2] = 1'b1;
    cyc(HOLD - 1);
    en100[2] = 1'b0;
    cyc(1);
    chk("R6 drop on terminal edge holds reset", busy100, 4'b0100);
    en100[2] = 1'b1;
    cyc(HOLD - 1);
    chk("R6 terminal collision recount", busy100, 4'b0100);
    cyc(1);
    chk("R5 release after collision", busy100, 4'h0);
    chk("R11 10M untouched", busy10, 4'h0);
  endtask

  task automatic t_short_pulse;
    #1 hw_rst = 1'b1;
    #2 hw_rst = 1'b0;
    #1;
    chk("R1 short pulse busy", busy, 4'hF);
    chk("R1 short pulse busy100", busy100, 4'hF);
    @(negedge clk);
    cyc(HOLD);
    chk("R3 release timing after pulse", busy10, 4'hF);
    cyc(1);
    chk("R1 recovered", busy, 4'h0);
  endtask

  task automatic t_por;
    en10[3] = 1'b0;
    por_rst = 1'b1;
    #1;
    chk("R2 por forces busy", busy, 4'hF);
    cyc(2);
    por_rst = 1'b0;
    cyc(HOLD + 2);
    chk("R2 por release busy10", busy10, 4'b1000);
    chk("R7 port with one section busy", busy, 4'b1000);
    chk("R2 por release busy100", busy100, 4'h0);
    en10[3] = 1'b1;
    cyc(HOLD);
    chk("R4 late enable released", busy, 4'h0);
  endtask

  task automatic t_pll;
    en10 = '0; en100 = '0;
    cyc(1);
    chk("R8 pll160 off", pll160_en, 1'b0);
    chk("R9 pll125 off", pll125_en, 1'b0);
    byp160 = 1'b1;
    #1 chk("R8 registered latency", pll160_en, 1'b0);
    cyc(1);
    chk("R8 bypass on", pll160_en, 1'b1);
    byp160 = 1'b0; en10 = 4'b0100;
    cyc(1);
    chk("R8 one port 10M", pll160_en, 1'b1);
    en10 = '0; in125_sel = 1'b1;
    cyc(1);
    chk("R8 off again", pll160_en, 1'b0);
    chk("R9 freq select", pll125_en, 1'b1);
    in125_sel = 1'b0; byp125 = 1'b1;
    cyc(1);
    chk("R9 bypass", pll125_en, 1'b1);
    byp125 = 1'b0; en100 = 4'b1000;
    cyc(1);
    chk("R9 one port 100M", pll125_en, 1'b1);
    en100 = '0;
    cyc(1);
    chk("R9 off", pll125_en, 1'b0);
  endtask

  task automatic t_clk_sel;
    sel_ref = 1'b1; sel_xtl = 1'b0;
    cyc(1);
    chk("R10 single select ok", clk_sel_err, 1'b0);
    sel_xtl = 1'b1;
    #1 chk("R10 registered latency", clk_sel_err, 1'b0);
    cyc(1);
    chk("R10 conflict", clk_sel_err, 1'b1);
    sel_ref = 1'b0;
    cyc(1);
    chk("R10 cleared", clk_sel_err, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_bring_up();
    t_section_restart();
    t_drop_at_terminal();
    t_short_pulse();
    t_por();
    t_pll();
    t_clk_sel();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule